// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function-code fields of a 32-bit instruction into the control word that a single-cycle datapath needs. A first-level decoder reads the 6-bit opcode. It produces the register-file write enable, the second-operand select, the writeback source select, the destination-register select, the data-memory read and write strobes, a branch-on-equal flag, a jump flag, and a 2-bit ALU class. A second-level decoder combines that class with the 6-bit function code to form a 3-bit ALU operation code.

The decoder also picks the register number to write: the rd field or the rt field of the instruction. The whole control word is captured in one output register with a synchronous active-high reset. A datapath that presents the fields of an instruction on one clock edge sees the matching controls after the next rising edge.

The opcodes it recognises are register-format, load word, store word, branch-on-equal and jump. Any other opcode, and any register-format instruction whose function code is not recognised, produces a harmless control word: no write enable of any kind and an add operation.

Top module: `ctrl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next output values are: every 1-bit control 0, `alu_class` 00, `alu_op` 100 (add) and `wr_reg` 0.
- R2: Opcode 000000 with a recognised function code gives `reg_wr`=1, `dst_is_rd`=1 and `alu_class`=10. All other 1-bit controls are 0.
- R3: When `alu_class` is 10, the function code selects `alu_op` as follows: 100100→000 (and), 100101→010 (or), 100000→100 (add), 100010→101 (sub), 101010→111 (set-less-than).
- R4: Opcode 100011 (load) gives `reg_wr`, `alu_src_imm`, `mem_to_reg` and `mem_rd` all 1. The other 1-bit controls are 0, with `alu_class` 00 and `alu_op` 100.
- R5: Opcode 101011 (store) gives `alu_src_imm`=1 and `mem_wr`=1. The other 1-bit controls are 0, with `alu_class` 00 and `alu_op` 100. `mem_rd` and `mem_wr` are never both 1.
- R6: Opcode 000100 (branch-on-equal) gives `br_eq`=1. The other 1-bit controls are 0, with `alu_class` 01 and `alu_op` 101.
- R7: Opcode 000010 (jump) gives `jump`=1. The other 1-bit controls are 0, with `alu_class` 00 and `alu_op` 100.
- R8: `wr_reg` equals the registered `rd_idx` when `dst_is_rd` is 1. Otherwise it equals the registered `rt_idx`.
- R9: Any opcode other than the five above gives every 1-bit control 0, `alu_class` 00 and `alu_op` 100. At most one of `reg_wr`, `mem_wr`, `br_eq` and `jump` is ever 1.
- R10: Opcode 000000 with a function code outside the R3 list gives every 1-bit control 0, `alu_class` 00 and `alu_op` 100.
- R11: The outputs change only at a rising edge. They reflect the inputs sampled at the previous rising edge, so there is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Instruction bits 31..26 |
| fn_code | input | 6 | Instruction bits 5..0 |
| rt_idx | input | 5 | Instruction bits 20..16 |
| rd_idx | input | 5 | Instruction bits 15..11 |
| reg_wr | output | 1 | Register-file write enable |
| alu_src_imm | output | 1 | Second ALU operand is the immediate |
| mem_to_reg | output | 1 | Writeback from memory rather than ALU |
| dst_is_rd | output | 1 | Destination register comes from rd |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| br_eq | output | 1 | Branch-on-equal instruction |
| jump | output | 1 | Jump instruction |
| alu_class | output | 2 | 00 add, 01 subtract, 10 by function code, 11 reserved |
| alu_op | output | 3 | ALU operation code |
| wr_reg | output | 5 | Register number to write |

## Verification
The bench sweeps every pairing of opcode and function code, so it covers each unlisted code as well as the listed ones. That sweep catches a decoder that leaves a stray write enable on for an undefined opcode, and one that writes a register for a register-format instruction with an unknown function code. It also catches a swap between the or and set-less-than encodings, or between add and subtract. The rd and rt fields differ on every vector, so a wrong destination select shows up as a wrong register number. The bench also checks the outputs just after each input change, to expose a path that is not registered. It applies a reset in the middle of the run, to expose a reset that fails to restore the add operation.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int OPC_W = 6;
  localparam int FNC_W = 6;
  localparam int AOP_W = 3;
  localparam int ACL_W = 2;

  typedef enum logic [ACL_W-1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_RSVD = 2'b11
  } alu_class_e;

  typedef enum logic [AOP_W-1:0] {
    AOP_AND = 3'b000,
    AOP_OR  = 3'b010,
    AOP_ADD = 3'b100,
    AOP_SUB = 3'b101,
    AOP_SLT = 3'b111
  } alu_op_e;

  localparam logic [OPC_W-1:0] OPC_RFMT  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [FNC_W-1:0] FNC_ADD = 6'b100000;
  localparam logic [FNC_W-1:0] FNC_SUB = 6'b100010;
  localparam logic [FNC_W-1:0] FNC_AND = 6'b100100;
  localparam logic [FNC_W-1:0] FNC_OR  = 6'b100101;
  localparam logic [FNC_W-1:0] FNC_SLT = 6'b101010;

  typedef struct packed {
    logic       reg_wr;
    logic       alu_src_imm;
    logic       mem_to_reg;
    logic       dst_is_rd;
    logic       mem_rd;
    logic       mem_wr;
    logic       br_eq;
    logic       jump;
    alu_class_e alu_class;
  } main_ctrl_t;

  localparam int MAIN_W = $bits(main_ctrl_t);

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] op_code,
  output main_ctrl_t       ctrl,
  output logic             is_rfmt
);

  always_comb begin
    ctrl      = '0;
    ctrl.alu_class = CLS_ADD;
    is_rfmt   = 1'b0;
    unique case (op_code)
      OPC_RFMT: begin
        is_rfmt        = 1'b1;
        ctrl.reg_wr    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.alu_class = CLS_FUNC;
      end
      OPC_LOAD: begin
        ctrl.reg_wr      = 1'b1;
        ctrl.alu_src_imm = 1'b1;
        ctrl.mem_to_reg  = 1'b1;
        ctrl.mem_rd      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.alu_src_imm = 1'b1;
        ctrl.mem_wr      = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.br_eq     = 1'b1;
        ctrl.alu_class = CLS_SUB;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: begin
        ctrl = '0;
      end
    endcase
  end

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_dec_pkg::*;
(
  input  alu_class_e       alu_class,
  input  logic [FNC_W-1:0] fn_code,
  output alu_op_e          alu_op,
  output logic             fn_known
);

  always_comb begin
    alu_op   = AOP_ADD;
    fn_known = 1'b1;
    unique case (alu_class)
      CLS_ADD:  alu_op = AOP_ADD;
      CLS_SUB:  alu_op = AOP_SUB;
      CLS_FUNC: begin
        unique case (fn_code)
          FNC_ADD: alu_op = AOP_ADD;
          FNC_SUB: alu_op = AOP_SUB;
          FNC_AND: alu_op = AOP_AND;
          FNC_OR:  alu_op = AOP_OR;
          FNC_SLT: alu_op = AOP_SLT;
          default: begin
            alu_op   = AOP_ADD;
            fn_known = 1'b0;
          end
        endcase
      end
      default:  alu_op = AOP_ADD;
    endcase
  end

endmodule

// File: rtl/ctrl_out_reg.sv
module ctrl_out_reg #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [5:0]           op_code,
  input  logic [5:0]           fn_code,
  input  logic [REG_IDX_W-1:0] rt_idx,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic                 reg_wr,
  output logic                 alu_src_imm,
  output logic                 mem_to_reg,
  output logic                 dst_is_rd,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic                 br_eq,
  output logic                 jump,
  output logic [1:0]           alu_class,
  output logic [2:0]           alu_op,
  output logic [REG_IDX_W-1:0] wr_reg
);

  localparam int WORD_W = MAIN_W + AOP_W + REG_IDX_W;
  localparam logic [WORD_W-1:0] WORD_RST =
    {{MAIN_W{1'b0}}, AOP_ADD, {REG_IDX_W{1'b0}}};

  main_ctrl_t main_raw;
  main_ctrl_t main_eff;
  logic       is_rfmt;
  alu_op_e    op_raw;
  alu_op_e    op_eff;
  logic       fn_known;
  logic       fn_reject;
  logic [REG_IDX_W-1:0] dst_sel;
  logic [WORD_W-1:0]    word_d;
  logic [WORD_W-1:0]    word_q;

  ctrl_main_dec u_main (
    .op_code (op_code),
    .ctrl    (main_raw),
    .is_rfmt (is_rfmt)
  );

  ctrl_alu_dec u_alu (
    .alu_class (main_raw.alu_class),
    .fn_code   (fn_code),
    .alu_op    (op_raw),
    .fn_known  (fn_known)
  );

  // A register-format word with an unknown function code is squashed.
  assign fn_reject = is_rfmt & ~fn_known;

  always_comb begin
    if (fn_reject) begin
      main_eff = '0;
      op_eff   = AOP_ADD;
    end else begin
      main_eff = main_raw;
      op_eff   = op_raw;
    end
  end

  assign dst_sel = main_eff.dst_is_rd ? rd_idx : rt_idx;
  assign word_d  = {main_eff, op_eff, dst_sel};

  ctrl_out_reg #(
    .W       (WORD_W),
    .RST_VAL (WORD_RST)
  ) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (word_d),
    .q   (word_q)
  );

  assign {reg_wr, alu_src_imm, mem_to_reg, dst_is_rd, mem_rd, mem_wr,
          br_eq, jump, alu_class, alu_op, wr_reg} = word_q;

endmodule

// File: rtl/ctrl_dec_chk.sv
module ctrl_dec_chk #(
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [5:0]           op_code,
  input logic [5:0]           fn_code,
  input logic [REG_IDX_W-1:0] rt_idx,
  input logic [REG_IDX_W-1:0] rd_idx,
  input logic                 reg_wr,
  input logic                 alu_src_imm,
  input logic                 mem_to_reg,
  input logic                 dst_is_rd,
  input logic                 mem_rd,
  input logic                 mem_wr,
  input logic                 br_eq,
  input logic                 jump,
  input logic [1:0]           alu_class,
  input logic [2:0]           alu_op,
  input logic [REG_IDX_W-1:0] wr_reg
);

  logic op_known;
  assign op_known = (op_code == 6'b000000) || (op_code == 6'b100011) ||
                    (op_code == 6'b101011) || (op_code == 6'b000100) ||
                    (op_code == 6'b000010);

  p_mem_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_one_enable_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr, mem_wr, br_eq, jump}));

  p_load_path_r4: assert property (@(posedge clk) disable iff (rst)
    mem_to_reg |-> (mem_rd && reg_wr && alu_src_imm));

  p_branch_sub_r6: assert property (@(posedge clk) disable iff (rst)
    br_eq |-> (alu_op == 3'b101 && alu_class == 2'b01));

  p_jump_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    jump |-> !(reg_wr || mem_rd || mem_wr || br_eq));

  p_rd_pick_r8: assert property (@(posedge clk) disable iff (rst)
    dst_is_rd |-> (wr_reg == $past(rd_idx)));

  p_rt_pick_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !dst_is_rd) |-> (wr_reg == $past(rt_idx)));

  p_unknown_op_r9: assert property (@(posedge clk) disable iff (rst)
    !op_known |=> (!reg_wr && !mem_rd && !mem_wr && !br_eq && !jump &&
                   alu_op == 3'b100));

  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 6'b101011) |=> (mem_wr && alu_src_imm && !reg_wr));

  p_rfmt_add_r2: assert property (@(posedge clk) disable iff (rst)
    (op_code == 6'b000000 && fn_code == 6'b100000) |=>
      (reg_wr && dst_is_rd && alu_op == 3'b100));

endmodule

bind ctrl_decoder ctrl_dec_chk #(.REG_IDX_W(REG_IDX_W)) u_chk (
  .clk (clk), .rst (rst), .op_code (op_code), .fn_code (fn_code),
  .rt_idx (rt_idx), .rd_idx (rd_idx), .reg_wr (reg_wr),
  .alu_src_imm (alu_src_imm), .mem_to_reg (mem_to_reg),
  .dst_is_rd (dst_is_rd), .mem_rd (mem_rd), .mem_wr (mem_wr),
  .br_eq (br_eq), .jump (jump), .alu_class (alu_class),
  .alu_op (alu_op), .wr_reg (wr_reg)
);

// File: tb/tb_ctrl_decoder.sv
module tb_ctrl_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op_code = '0;
  logic [5:0] fn_code = '0;
  logic [4:0] rt_idx = '0;
  logic [4:0] rd_idx = '0;
  logic       reg_wr, alu_src_imm, mem_to_reg, dst_is_rd;
  logic       mem_rd, mem_wr, br_eq, jump;
  logic [1:0] alu_class;
  logic [2:0] alu_op;
  logic [4:0] wr_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctrl_decoder dut (
    .clk (clk), .rst (rst), .op_code (op_code), .fn_code (fn_code),
    .rt_idx (rt_idx), .rd_idx (rd_idx), .reg_wr (reg_wr),
    .alu_src_imm (alu_src_imm), .mem_to_reg (mem_to_reg),
    .dst_is_rd (dst_is_rd), .mem_rd (mem_rd), .mem_wr (mem_wr),
    .br_eq (br_eq), .jump (jump), .alu_class (alu_class),
    .alu_op (alu_op), .wr_reg (wr_reg)
  );

  localparam logic [17:0] RESET_WORD = {8'b0, 2'b00, 3'b100, 5'd0};

  function automatic logic [17:0] observed();
    return {reg_wr, alu_src_imm, mem_to_reg, dst_is_rd, mem_rd, mem_wr,
            br_eq, jump, alu_class, alu_op, wr_reg};
  endfunction

  // Expected word: {8 flags, class, op, wr_reg}, from the requirements.
  function automatic logic [17:0] expect_word(input logic [5:0] op,
      input logic [5:0] fn, input logic [4:0] rt, input logic [4:0] rd);
    logic [2:0] f;
    bit ok;
    ok = 1'b1;
    case (fn)
      6'd32: f = 3'd4;
      6'd34: f = 3'd5;
      6'd36: f = 3'd0;
      6'd37: f = 3'd2;
      6'd42: f = 3'd7;
      default: begin f = 3'd4; ok = 1'b0; end
    endcase
    case (op)
      6'd0:  return ok ? {8'b1001_0000, 2'b10, f, rd}
                       : {8'b0, 2'b00, 3'd4, rt};
      6'd35: return {8'b1110_1000, 2'b00, 3'd4, rt};
      6'd43: return {8'b0100_0100, 2'b00, 3'd4, rt};
      6'd4:  return {8'b0000_0010, 2'b01, 3'd5, rt};
      6'd2:  return {8'b0000_0001, 2'b00, 3'd4, rt};
      default: return {8'b0, 2'b00, 3'd4, rt};
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'd0:  return (fn == 6'd32 || fn == 6'd34 || fn == 6'd36 ||
                     fn == 6'd37 || fn == 6'd42) ? "R2,R3,R8" : "R10";
      6'd35: return "R4,R8";
      6'd43: return "R5";
      6'd4:  return "R6";
      6'd2:  return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [17:0] got,
                       input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                       input logic [4:0] rt, input logic [4:0] rd);
    op_code = op; fn_code = fn; rt_idx = rt; rd_idx = rd;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] prev;
    // R1: reset state while loaded with a load instruction
    drive(6'd35, 6'd0, 5'd3, 5'd9);
    @(negedge clk); @(negedge clk);
    check("R1", observed(), RESET_WORD);
    rst = 1'b0;
    @(negedge clk);
    prev = expect_word(6'd35, 6'd0, 5'd3, 5'd9);
    check("R4", observed(), prev);

    // Exhaustive sweep over opcode x function code, rt != rd everywhere.
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        logic [4:0] rt;
        logic [4:0] rd;
        rt = 5'((op * 7 + fn) % 32);
        rd = 5'((rt + 1 + (op + fn) % 30) % 32);
        drive(6'(op), 6'(fn), rt, rd);
        #1;
        check("R11", observed(), prev);
        @(negedge clk);
        prev = expect_word(6'(op), 6'(fn), rt, rd);
        check(tag_of(6'(op), 6'(fn)), observed(), prev);
      end
    end

    // R8: same fields, rd chosen for register format, rt for load.
    drive(6'd0, 6'd37, 5'd17, 5'd30);
    @(negedge clk);
    check("R8", {27'd0, wr_reg}, {27'd0, 5'd30});
    drive(6'd35, 6'd37, 5'd17, 5'd30);
    @(negedge clk);
    check("R8", {27'd0, wr_reg}, {27'd0, 5'd17});

    // R1: reset in mid-run overrides a register-format slt.
    drive(6'd0, 6'd42, 5'd5, 5'd6);
    @(negedge clk);
    check("R3", observed(), expect_word(6'd0, 6'd42, 5'd5, 5'd6));
    rst = 1'b1;
    @(negedge clk);
    check("R1", observed(), RESET_WORD);
    rst = 1'b0;
    @(negedge clk);
    check("R2", observed(), expect_word(6'd0, 6'd42, 5'd5, 5'd6));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule